// File: doc/BRIEF.md
# NRZ-to-Manchester Moore Encoder

This block turns a serial NRZ bit stream into Manchester code. It runs on a clock at twice the bit rate, so each bit time lasts two clock periods. The NRZ bit is taken at the first clock edge of its bit time. The machine then drives two half-bit levels on a registered output.

The core is a four-state Moore machine, so the output depends only on the state. The first half of each bit appears one clock after the edge that takes in the bit. A 0 bit is sent as low then high. A 1 bit is sent as high then low.

The input is read only in the two states that begin a bit time. In the other two states the machine ignores the input and always steps to the second half. A parameter chooses how the state is stored: a two-bit binary code or four one-hot flops. The behaviour at the ports is the same for both.

Top module: `mch_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters its rest state and `manch_out` is 0 after that edge. This holds whatever the value of `nrz_in`.
- R2: `nrz_in` is sampled only at the first rising edge of each bit time. That edge is the first one after reset is released, and every second edge after it.
- R3: A sampled 0 gives `manch_out` = 0 for the clock after the sampling edge, then `manch_out` = 1 for the next clock.
- R4: A sampled 1 gives `manch_out` = 1 for the clock after the sampling edge, then `manch_out` = 0 for the next clock.
- R5: `manch_out` changes level at the edge that ends the first half of every bit time, whatever the bit values.
- R6: Any value on `nrz_in` during the second clock of a bit time has no effect on `manch_out`.
- R7: `manch_out` is driven straight from a flop and matches the level of the current state: 1 in the two high states, 0 otherwise.
- R8: Raising `rst` in the middle of a bit time cancels that bit. After release, the next bit is encoded from its first half.
- R9: With `ONE_HOT` set to 0 or to 1, the output stream is identical for the same input, and the one-hot register always holds exactly one set bit outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| nrz_in | input | 1 | NRZ data bit, held for a whole bit time |
| manch_out | output | 1 | Registered Manchester output |

## Verification
The case hardest to reach from the ports is a change of `nrz_in` during the second clock of a bit time. A clean source never changes the input in that window, so only a deliberately corrupted source can show that the input is really ignored there. The stimulus inverts `nrz_in` at random inside that window, with a fixed seed, while checking both half-bit levels. Directed sequences add a reset in the middle of a bit, long runs of equal bits, and a fixed eight-bit pattern. Both state encodings run side by side on the same input.

// File: rtl/mch_pkg.sv
package mch_pkg;

  localparam int unsigned MCH_NUM_STATES = 4;
  localparam int unsigned MCH_STATE_W    = $clog2(MCH_NUM_STATES);

  // Rest/low second half of a 1, first half of a 0, first half of a 1,
  // high second half of a 0.
  typedef enum logic [MCH_STATE_W-1:0] {
    ST_REST_LO = 2'd0,
    ST_ZERO_A  = 2'd1,
    ST_ONE_A   = 2'd2,
    ST_ZERO_B  = 2'd3
  } mch_state_e;

  function automatic logic mch_level(input mch_state_e s);
    return (s == ST_ONE_A) || (s == ST_ZERO_B);
  endfunction

  function automatic logic mch_decides(input mch_state_e s);
    return (s == ST_REST_LO) || (s == ST_ZERO_B);
  endfunction

endpackage

// File: rtl/mch_next_state.sv
module mch_next_state
  import mch_pkg::*;
(
  input  mch_state_e st,
  input  logic       bit_in,
  output mch_state_e nxt
);

  always_comb begin
    unique case (st)
      ST_REST_LO: nxt = bit_in ? ST_ONE_A : ST_ZERO_A;
      ST_ZERO_A:  nxt = ST_ZERO_B;
      ST_ONE_A:   nxt = ST_REST_LO;
      ST_ZERO_B:  nxt = bit_in ? ST_ONE_A : ST_ZERO_A;
      default:    nxt = ST_REST_LO;
    endcase
  end

endmodule

// File: rtl/mch_state_reg.sv
module mch_state_reg
  import mch_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  mch_state_e nxt,
  output mch_state_e st
);

  localparam int unsigned NUM = MCH_NUM_STATES;

  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM-1:0] oh_q;

      always_ff @(posedge clk) begin
        if (rst) oh_q <= {{(NUM-1){1'b0}}, 1'b1};
        else     oh_q <= {{(NUM-1){1'b0}}, 1'b1} << nxt;
      end

      always_comb begin
        st = ST_REST_LO;
        for (int i = 0; i < NUM; i++) begin
          if (oh_q[i]) st = mch_state_e'(MCH_STATE_W'(i));
        end
      end

      assert_onehot_state_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(oh_q) == 1)
        else $error("one-hot state register lost its single set bit");
    end else begin : g_binary
      mch_state_e st_q;

      always_ff @(posedge clk) begin
        if (rst) st_q <= ST_REST_LO;
        else     st_q <= nxt;
      end

      assign st = st_q;
    end
  endgenerate

endmodule

// File: rtl/mch_out_reg.sv
module mch_out_reg
  import mch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mch_state_e nxt,
  output logic       z
);

  // The output flop is loaded from the next state, so it tracks the
  // state register without a decode stage after it.
  always_ff @(posedge clk) begin
    if (rst) z <= 1'b0;
    else     z <= mch_level(nxt);
  end

endmodule

// File: rtl/mch_encoder.sv
module mch_encoder
  import mch_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nrz_in,
  output logic manch_out
);

  mch_state_e st;
  mch_state_e nxt;

  mch_next_state u_next (
    .st     (st),
    .bit_in (nrz_in),
    .nxt    (nxt)
  );

  mch_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .st  (st)
  );

  mch_out_reg u_out (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .z   (manch_out)
  );

  assert_reset_rest_R1: assert property (@(posedge clk)
    rst |=> (st == ST_REST_LO) && !manch_out)
    else $error("reset did not reach the rest state");

  assert_zero_first_R3: assert property (@(posedge clk) disable iff (rst)
    (mch_decides(st) && !nrz_in) |=> (st == ST_ZERO_A) && !manch_out)
    else $error("0 bit did not start low");

  assert_one_first_R4: assert property (@(posedge clk) disable iff (rst)
    (mch_decides(st) && nrz_in) |=> (st == ST_ONE_A) && manch_out)
    else $error("1 bit did not start high");

  assert_mid_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_ZERO_A) || (st == ST_ONE_A)) |=> (manch_out != $past(manch_out)))
    else $error("no transition in the middle of a bit");

  assert_zero_second_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ZERO_A) |=> (st == ST_ZERO_B))
    else $error("second half of 0 depended on input");

  assert_one_second_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ONE_A) |=> (st == ST_REST_LO))
    else $error("second half of 1 depended on input");

  assert_out_matches_state_R7: assert property (@(posedge clk) disable iff (rst)
    manch_out == mch_level(st))
    else $error("output flop disagrees with state");

endmodule

// File: tb/mch_encoder_bench.sv
module mch_encoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nrz_in = 1'b0;
  logic z_bin;
  logic z_oh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mch_encoder #(.ONE_HOT(1'b0)) u_mch_encoder (
    .clk (clk), .rst (rst), .nrz_in (nrz_in), .manch_out (z_bin)
  );

  mch_encoder #(.ONE_HOT(1'b1)) u_mch_encoder_oh (
    .clk (clk), .rst (rst), .nrz_in (nrz_in), .manch_out (z_oh)
  );

  // Expected level: first half equals the bit, second half its inverse.
  function automatic logic exp_half(input logic b, input bit second);
    return second ? ~b : b;
  endfunction

  task automatic chk(input string req, input logic got_bin, input logic got_oh,
                     input logic exp);
    checks++;
    if (got_bin !== exp) begin
      errors++;
      $display("FAIL %s binary: got %b expected %b", req, got_bin, exp);
    end
    checks++;
    if (got_oh !== exp) begin
      errors++;
      $display("FAIL %s one-hot: got %b expected %b", req, got_oh, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are sampled there too.
  task automatic send_bit(input logic b, input bit glitch, input string req);
    nrz_in = b;
    @(posedge clk);
    @(negedge clk);
    chk(req, z_bin, z_oh, exp_half(b, 1'b0));
    if (glitch) nrz_in = ~b;
    @(posedge clk);
    @(negedge clk);
    chk(req, z_bin, z_oh, exp_half(b, 1'b1));
  endtask

  initial begin
    logic [7:0] pattern;
    void'($urandom(32'd4711));
    // R1: reset state, with the input high during reset
    nrz_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", z_bin, z_oh, 1'b0);
    rst = 1'b0;

    // R2 R3 R4: fixed pattern, msb first: 0 1 1 1 0 0 1 0
    pattern = 8'b0111_0010;
    for (int i = 7; i >= 0; i--) send_bit(pattern[i], 1'b0, "R2");

    // R5: runs of equal bits, still a transition every bit
    for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0, "R5");
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0, "R5");

    // R6: input inverted during the second clock of every bit
    for (int i = 0; i < 8; i++) send_bit(i[0], 1'b1, "R6");

    // R8: reset in the middle of a bit, then a fresh bit
    nrz_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R4", z_bin, z_oh, 1'b1);
    rst = 1'b1;
    nrz_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8", z_bin, z_oh, 1'b0);
    rst = 1'b0;
    send_bit(1'b0, 1'b0, "R8");
    send_bit(1'b1, 1'b0, "R8");

    // R1: reset while the machine is in a first half of a 0
    nrz_in = 1'b0;
    @(posedge clk);
    rst = 1'b1;
    nrz_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", z_bin, z_oh, 1'b0);
    rst = 1'b0;

    // R3 R4 R6 R9: random stream, random glitches in the second half
    for (int i = 0; i < 400; i++) begin
      logic b;
      bit g;
      b = 1'($urandom);
      g = ($urandom % 3) == 0;
      send_bit(b, g, "R9");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule